// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

A 32-bit processor core that finishes one instruction every clock cycle. It carries its own program counter, next-PC selection, a 32-entry register file, immediate sign extension, a shared add/subtract/logic unit and a two-level instruction decoder. Instructions come in over a word-wide fetch port. Loads and stores use a separate data port that has an address, write data, a write strobe and combinational read data.

The core runs a small load/store instruction subset: register add, subtract, AND, OR and signed set-less-than; add-immediate; word load and word store; branch-if-equal; and an absolute jump. It uses fixed 32-bit instruction words. The opcode sits in bits 31:26, the first source register in 25:21, the second source (or the immediate-form destination) in 20:16, the register-form destination in 15:11, the function code in 5:0, the 16-bit immediate in 15:0 and the jump index in 25:0. Register 0 is hardwired to zero. Any encoding outside the subset runs as a no-op.

Top module: `onecyc_core`

## Requirements
- R1: While rst_n is low (asynchronous, active-low), the fetch address is 0, dmem_we is low and every register reads 0. The first instruction after release is fetched from address 0.
- R2: After any instruction other than a taken branch or a jump, the next fetch address is the current one plus 4.
- R3: Opcode 000000 is register form and writes field 15:11. Function code 100000 adds, 100010 subtracts (first minus second), 100100 ANDs and 100101 ORs.
- R4: Register-form function code 101010 writes 1 when bit 31 of the wrapped difference (first minus second) is set, and writes 0 otherwise.
- R5: Opcode 001000 writes the first source plus the sign-extended immediate into register field 20:16.
- R6: Opcode 100011 drives dmem_addr with the first source plus the sign-extended immediate and writes dmem_rdata into register field 20:16.
- R7: Opcode 101011 drives that same address, drives dmem_wdata with the register named by field 20:16 and raises dmem_we. No other instruction raises dmem_we.
- R8: Opcode 000100 branches when both source registers are equal. The target is the current address plus 4 plus the sign-extended immediate shifted left by 2. When the registers differ, execution falls through to the next word.
- R9: Opcode 000010 jumps to {bits 31:28 of address+4, index 25:0, 2'b00}. A jump overrides any other next-address choice.
- R10: Register 0 always reads 0, and writes to it are dropped.
- R11: An opcode outside the subset, or opcode 000000 with any other function code, writes no register, does not raise dmem_we and advances the fetch address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data address computed by the ALU |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, memory writes on the rising edge |
| dmem_rdata | input | 32 | Combinational load data at dmem_addr |

## Verification
Assertions check the following properties on every cycle: next-address sequencing, branch and jump targets, that stores come only from the store opcode, that the decoder never asserts more than one of register write, store, branch and jump, that a register write lands in the addressed entry, and the fetch address after reset. Some results can only be seen through the ports across many instructions, so the bench scenarios show them. These include the arithmetic and set-less-than values, load write-back, the register-0 discard and the silence of unsupported encodings. A directed program and a seeded random program are both checked against a bench instruction-level model, instruction by instruction.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND  = 3'b000,
    ALU_OR   = 3'b001,
    ALU_ADD  = 3'b010,
    ALU_ANDN = 3'b100,
    ALU_ORN  = 3'b101,
    ALU_SUB  = 3'b110,
    ALU_SLT  = 3'b111
  } alu_code_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    is_branch;
    logic    mem_we;
    logic    wb_mem;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/onecyc_ctrl.sv
module onecyc_ctrl
  import onecyc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output alu_code_e  alu_code
);
  ctrl_t     main_ctl;
  logic      funct_ok;

  always_comb begin
    unique case (funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: funct_ok = 1'b1;
      default:                               funct_ok = 1'b0;
    endcase
  end

  // first level: opcode to control word, unused fields held at 0
  always_comb begin
    main_ctl = '0;
    unique case (opcode)
      OP_REG:  main_ctl = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AOP_FUNCT};
      OP_LOAD: main_ctl = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, AOP_ADD};
      OP_STOR: main_ctl = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, AOP_ADD};
      OP_BEQ:  main_ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AOP_SUB};
      OP_ADDI: main_ctl = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, AOP_ADD};
      OP_JMP:  main_ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AOP_ADD};
      default: main_ctl = '0;
    endcase
  end

  // unsupported function codes in register form become a no-op
  always_comb begin
    ctl = main_ctl;
    if (main_ctl.alu_op == AOP_FUNCT && !funct_ok) ctl.reg_we = 1'b0;
  end

  // second level: ALU op and function code to ALU code
  always_comb begin
    unique case (main_ctl.alu_op)
      AOP_ADD: alu_code = ALU_ADD;
      AOP_SUB: alu_code = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_SUB:  alu_code = ALU_SUB;
          FN_AND:  alu_code = ALU_AND;
          FN_OR:   alu_code = ALU_OR;
          FN_SLT:  alu_code = ALU_SLT;
          default: alu_code = ALU_ADD;
        endcase
      end
      default: alu_code = ALU_ADD;
    endcase
  end

  always_comb begin
    a_r11_bad_funct_silent: assert (!(opcode == OP_REG && !funct_ok) || !ctl.reg_we);
  end
endmodule

// File: rtl/onecyc_rf.sv
module onecyc_rf #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      logic en;
      assign en = we && (wa == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[i] <= '0;
        else if (en) regs[i] <= wd;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
  a_r10_zero_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == '0) |=> regs[0] == '0);
endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
  import onecyc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_code_e    code,
  output logic [W-1:0] y,
  output logic         zero
);
  logic         inv;
  logic [W-1:0] b_sel;
  logic [W-1:0] sum;

  assign inv   = code[2];
  assign b_sel = inv ? ~b : b;
  assign sum   = a + b_sel + W'(inv);

  always_comb begin
    unique case (code[1:0])
      2'b00:   y = a & b_sel;
      2'b01:   y = a | b_sel;
      2'b10:   y = sum;
      default: y = W'(sum[W-1]);
    endcase
  end

  assign zero = (y == '0);

  always_comb begin
    a_r8_sub_zero_means_equal: assert (code != ALU_SUB || zero == (a == b));
  end
endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import onecyc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int W = XLEN;

  logic [W-1:0]      pc, pc_nxt, pc_plus4, br_target, jmp_target;
  logic [W-1:0]      imm_sx, src_a, src_b, alu_b, alu_y, wb_data;
  logic [RIDX_W-1:0] wr_idx;
  logic              alu_zero, take_br;
  ctrl_t             ctl;
  alu_code_e         alu_code;

  onecyc_ctrl u_ctrl (
    .opcode   (imem_rdata[31:26]),
    .funct    (imem_rdata[5:0]),
    .ctl      (ctl),
    .alu_code (alu_code)
  );

  assign imm_sx = {{(W-16){imem_rdata[15]}}, imem_rdata[15:0]};
  assign wr_idx = ctl.dst_rd ? imem_rdata[15:11] : imem_rdata[20:16];
  assign wb_data = ctl.wb_mem ? dmem_rdata : alu_y;

  onecyc_rf #(.W(W), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (imem_rdata[25:21]),
    .ra2   (imem_rdata[20:16]),
    .rd1   (src_a),
    .rd2   (src_b),
    .we    (ctl.reg_we),
    .wa    (wr_idx),
    .wd    (wb_data)
  );

  assign alu_b = ctl.src_imm ? imm_sx : src_b;

  onecyc_alu #(.W(W)) u_alu (
    .a    (src_a),
    .b    (alu_b),
    .code (alu_code),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // next-address selection; jump overrides branch and fall-through
  assign pc_plus4   = pc + W'(4);
  assign br_target  = pc_plus4 + {imm_sx[W-3:0], 2'b00};
  assign jmp_target = {pc_plus4[W-1:28], imem_rdata[25:0], 2'b00};
  assign take_br    = ctl.is_branch && alu_zero;

  always_comb begin
    if (ctl.is_jump)  pc_nxt = jmp_target;
    else if (take_br) pc_nxt = br_target;
    else              pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_we    = ctl.mem_we && rst_n;

  a_r1_fetch_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> imem_addr == '0);
  a_r2_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.is_jump && !(ctl.is_branch && alu_zero)) |=> imem_addr == $past(imem_addr) + 32'd4);
  a_r8_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.is_branch && src_a == src_b) |=>
      imem_addr == $past(imem_addr) + 32'd4 + {$past(imem_rdata[29:0]) & 30'h0000_ffff
                   | {30{$past(imem_rdata[15])}} & 30'h3fff_0000, 2'b00});
  a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == OP_JMP) |=>
      imem_addr == {$past(imem_addr[31:28] + 4'(imem_addr[27:2] == 26'h3ff_ffff)),
                    $past(imem_rdata[25:0]), 2'b00});
  a_r7_store_opcode_only: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> imem_rdata[31:26] == OP_STOR);
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.reg_we, ctl.mem_we, ctl.is_branch, ctl.is_jump}));
endmodule

// File: tb/tb_onecyc_core.sv
module tb_onecyc_core;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_WORDS = 256;
  localparam int DMEM_WORDS = 64;
  localparam int RAND_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_pc;
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DMEM_WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  onecyc_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'b000010, idx};
  endfunction

  function automatic bit fn_valid(logic [5:0] fn);
    return fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2a;
  endfunction

  function automatic string req_of(logic [31:0] ins);
    case (ins[31:26])
      6'h00:   return fn_valid(ins[5:0]) ? (ins[5:0] == 6'h2a ? "R4" : "R3") : "R11";
      6'h23:   return "R6";
      6'h2b:   return ins[20:16] == 5'd0 ? "R10" : "R7";
      6'h04:   return "R8";
      6'h08:   return ins[20:16] == 5'd0 ? "R10" : "R5";
      6'h02:   return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] alu_ref(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    case (fn)
      6'h20:   return a + b;
      6'h22:   return d;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: return {31'd0, d[31]};
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 32'd0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
  endtask

  task automatic load_dmem();
    for (int i = 0; i < DMEM_WORDS; i++) begin
      dmem[i] = 32'h9e37_79b9 * (i + 1);
      m_dm[i] = 32'h9e37_79b9 * (i + 1);
    end
  endtask

  // check the ports for the instruction at the model PC, then advance the model
  task automatic step_and_check();
    logic [31:0] ins, a, b, sx, pc4, nxt, addr;
    logic [5:0]  op;
    string       rq;
    ins  = imem[m_pc[9:2]];
    op   = ins[31:26];
    a    = m_rf[ins[25:21]];
    b    = m_rf[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    pc4  = m_pc + 32'd4;
    nxt  = pc4;
    addr = a + sx;
    rq   = req_of(ins);
    check((op == 6'h04 || op == 6'h02) ? rq : "R2", "fetch address", imem_addr, m_pc);
    check(op == 6'h2b ? "R7" : rq, "store strobe", {31'd0, dmem_we}, {31'd0, op == 6'h2b});
    if (op == 6'h2b || op == 6'h23) check(rq, "data address", dmem_addr, addr);
    if (op == 6'h2b) check(rq, "store data", dmem_wdata, b);
    case (op)
      6'h00: if (fn_valid(ins[5:0]) && ins[15:11] != 5'd0)
               m_rf[ins[15:11]] = alu_ref(ins[5:0], a, b);
      6'h23: if (ins[20:16] != 5'd0) m_rf[ins[20:16]] = m_dm[addr[7:2]];
      6'h2b: m_dm[addr[7:2]] = b;
      6'h04: if (a == b) nxt = pc4 + {sx[29:0], 2'b00};
      6'h08: if (ins[20:16] != 5'd0) m_rf[ins[20:16]] = addr;
      6'h02: nxt = {pc4[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    m_pc = nxt;
  endtask

  task automatic run_phase(int cycles);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    check("R1", "fetch address in reset", imem_addr, 32'd0);
    check("R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    step_and_check();
    for (int c = 1; c < cycles; c++) begin
      @(negedge clk);
      #1;
      step_and_check();
    end
  endtask

  function automatic logic [31:0] rand_ins();
    int k, rs, rt, rd;
    logic [5:0] fns [5];
    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2a};
    k  = int'($urandom % 20);
    rs = int'($urandom % 8);
    rt = int'($urandom % 8);
    rd = int'($urandom % 8);
    if (k < 6)       return enc_r(rs, rt, rd, fns[$urandom % 5]);
    else if (k < 9)  return enc_i(6'h08, rs, rt, 16'($urandom));
    else if (k < 12) return enc_i(6'h2b, rs, rt, 16'($urandom % 256));
    else if (k < 14) return enc_i(6'h23, rs, rt, 16'($urandom % 256));
    else if (k < 16) return enc_i(6'h04, rs, rt, 16'(int'($urandom % 9) - 3));
    else if (k < 17) return enc_j(26'($urandom % IMEM_WORDS));
    else if (k < 18) return enc_r(rs, rt, rd, 6'h3f);
    else if (k < 19) return {6'b111111, 26'($urandom)};
    else             return enc_i(6'h08, rs, 0, 16'($urandom));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed program covering the corner cases
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = 32'hfc00_0000;
    imem[0]  = enc_i(6'h08, 0, 1, 16'hfffb);     // r1 = -5 (R5)
    imem[1]  = enc_i(6'h08, 0, 2, 16'd7);        // r2 = 7
    imem[2]  = enc_r(1, 2, 3, 6'h2a);            // R4: -5 < 7 -> 1
    imem[3]  = enc_r(2, 1, 4, 6'h2a);            // R4: 7 < -5 -> 0
    imem[4]  = enc_r(1, 2, 5, 6'h22);            // R3 sub
    imem[5]  = enc_r(1, 2, 6, 6'h24);            // R3 and
    imem[6]  = enc_r(1, 2, 7, 6'h25);            // R3 or
    imem[7]  = enc_r(1, 2, 8, 6'h20);            // R3 add
    imem[8]  = enc_i(6'h08, 0, 0, 16'd9);        // R10 write to r0
    imem[9]  = enc_i(6'h2b, 0, 0, 16'd0);        // R10 r0 still zero
    imem[10] = enc_i(6'h2b, 2, 3, 16'd4);        // R7 store r3 at 11
    imem[11] = enc_i(6'h23, 0, 9, 16'd8);        // R6 load r9
    imem[12] = 32'hfc22_1234;                    // R11 unknown opcode
    imem[13] = enc_r(2, 2, 1, 6'h3f);            // R11 unknown funct, r1 kept
    imem[14] = enc_i(6'h2b, 1, 1, 16'd12);       // exposes r1 = -5
    imem[15] = enc_i(6'h2b, 0, 9, 16'd16);       // exposes loaded r9
    imem[16] = enc_i(6'h04, 1, 2, 16'd5);        // R8 not taken
    imem[17] = enc_i(6'h04, 3, 3, 16'd2);        // R8 taken to 20
    imem[18] = enc_i(6'h08, 0, 10, 16'd1);
    imem[19] = enc_i(6'h08, 0, 10, 16'd2);
    imem[20] = enc_j(26'd23);                    // R9 jump to 23
    imem[21] = enc_i(6'h08, 0, 11, 16'd1);
    imem[22] = enc_i(6'h08, 0, 11, 16'd2);
    imem[23] = enc_i(6'h2b, 0, 5, 16'd20);       // exposes sub result
    imem[24] = enc_i(6'h2b, 0, 6, 16'd24);
    imem[25] = enc_i(6'h2b, 0, 7, 16'd28);
    imem[26] = enc_i(6'h2b, 0, 8, 16'd32);
    imem[27] = enc_i(6'h2b, 0, 4, 16'd36);
    imem[28] = enc_i(6'h04, 0, 0, 16'hffff);     // R8 backward, loops here
    load_dmem();
    run_phase(40);

    // seeded random program, word 0 is a store to test reset gating
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = rand_ins();
    imem[0] = enc_i(6'h2b, 0, 0, 16'd0);
    load_dmem();
    run_phase(RAND_CYCLES);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule